// File: doc/BRIEF.md
# Serial Management Status Receiver

This block listens to a clocked serial stream (non-return-to-zero data, a receive clock whose falling edge moves the data, and a carrier-sense frame marker whose active level is configurable) and pulls a 56-bit status record out of each frame. The serial inputs are brought into the system clock domain, bits are taken on the rising edge of the receive clock, and a start-of-frame byte is searched for. After that byte, a sliding window always holds the most recent 56 bits, so the record is the tail of a frame of any length.

When carrier sense goes inactive, the frame is judged. A missing start byte, or fewer than 56 bits after it, gives a bus-error pulse. Otherwise the 6-bit device ID in the record is compared with two configured IDs. A match selects section 0 or section 1, and the 4-bit port field is then range checked. A good record is offered on a valid/ready output to the attribute updater. A bad port gives a port-error pulse. A record that matches neither ID is dropped without a flag.

Back-pressure rules on the record output: `rec_valid` stays high with stable `rec_data`, `rec_sel` and `rec_port` until a cycle where `rec_ready` is high. A new good record can load in the same cycle the held one is accepted. A good record that completes while an earlier one is still held and not accepted is discarded, and the held record is kept. Error pulses are never held back.

Top module: `mgmt_status_rx`

## Requirements
- R1: While `rst_n` is low, and after it is released with no traffic, `rec_valid`, `err_bus` and `err_port` are 0.
- R2: With `crs_pol` = 1, carrier is active when `mcrs` is high. With `crs_pol` = 0, carrier is active when `mcrs` is low.
- R3: Bits are taken from `mrxd` on rising edges of `mrxc` while carrier is active. `rec_data[i]` is the i-th of the last 56 bits received before carrier went inactive, so record byte k is `rec_data[8k+7:8k]` with its first-received bit as LSB. Bits received earlier in a long frame are discarded.
- R4: The start byte is 0xD5 sent LSB first (bit order 1,0,1,0,1,0,1,1). A frame in which it never appears gives a one-cycle `err_bus` pulse and no record.
- R5: A frame with fewer than 56 bits after the start byte gives a one-cycle `err_bus` pulse and no record. Exactly 56 bits is accepted.
- R6: The device ID is `rec_data[5:0]`. A match with `id0` gives `rec_sel` = 0, otherwise a match with `id1` gives `rec_sel` = 1. When both match, `id0` wins.
- R7: A complete record whose ID matches neither `id0` nor `id1` gives no record and no error pulse.
- R8: The port is `rec_data[11:8]` and is driven on `rec_port`. If the ID matches and the port is above 13, a one-cycle `err_port` pulse is given and no record is offered. Port 13 is accepted.
- R9: While `en` is 0, frames produce no record and no error. A frame counts only if `en` was 1 when its carrier became active and stays 1 until the carrier ends.
- R10: Results (record valid or error pulse) appear exactly four system clocks after the carrier-inactive level reaches the pin, and each error pulse lasts one cycle.
- R11: A held record keeps `rec_valid` high with stable contents until `rec_ready` is 1. A good record that completes while an earlier record is held and not accepted is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (40 MHz class) |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Processing enable |
| crs_pol | input | 1 | Carrier-sense active level: 1 high, 0 low |
| id0 | input | 6 | Device ID selecting section 0 |
| id1 | input | 6 | Device ID selecting section 1 |
| mrxc | input | 1 | Serial receive clock (asynchronous) |
| mrxd | input | 1 | Serial receive data |
| mcrs | input | 1 | Carrier sense framing the serial data |
| rec_valid | output | 1 | Status record offered |
| rec_ready | input | 1 | Downstream accepts the record |
| rec_data | output | 56 | The status record, bit 0 first received |
| rec_sel | output | 1 | Section chosen by the ID match |
| rec_port | output | 4 | Port field of the record |
| err_bus | output | 1 | One-cycle pulse: no start byte or short status |
| err_port | output | 1 | One-cycle pulse: matching ID with a port above 13 |

## Verification
Every frame outcome is due four system clocks after the bench drives carrier inactive: two synchronizer stages, the frame-end register in the shifter, and the output register in the validator. For each frame the bench samples on falling clock edges. At the third edge it expects nothing new. At the fourth it expects the record or error. At the fifth it expects error pulses to be gone and an accepted record to be cleared. Bits are driven at four system clocks per serial bit, with the data changing while the receive clock is low, so every capture point follows from the count of synchronizer stages and needs no polling.

// File: rtl/mgmt_rx_pkg.sv
package mgmt_rx_pkg;

  // Frame tracking in the shifter
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,  // no frame open
    FR_HUNT = 2'd1,  // carrier active, searching for the start byte
    FR_BODY = 2'd2   // start byte seen, counting status bits
  } frame_state_e;

  // Saturating increment used by the status bit counter
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/mgmt_sync.sv
module mgmt_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[LAST];
  end

endmodule

// File: rtl/mgmt_shifter.sv
module mgmt_shifter
  import mgmt_rx_pkg::*;
#(
  parameter int              REC_BITS = 56,
  parameter int              SFD_W    = 8,
  parameter logic [SFD_W-1:0] SFD_VAL = 8'hD5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                crs_pol,
  input  logic                crs_s,
  input  logic                rxc_s,
  input  logic                rxd_s,
  output logic                done,
  output logic                good,
  output logic [REC_BITS-1:0] window
);

  localparam int CNT_W = $clog2(REC_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(REC_BITS);

  frame_state_e     state;
  logic [SFD_W-1:0] sfd_sh;
  logic [CNT_W-1:0] cnt;
  logic             crs_d, rxc_d;

  logic             act, act_d, car_rise, car_fall, bit_stb;
  logic [SFD_W-1:0] sfd_next;

  always_comb begin
    act      = crs_pol ? crs_s : ~crs_s;
    act_d    = crs_pol ? crs_d : ~crs_d;
    car_rise = act & ~act_d;
    car_fall = ~act & act_d;
    bit_stb  = act & rxc_s & ~rxc_d;
    sfd_next = {rxd_s, sfd_sh[SFD_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crs_d <= 1'b0;
      rxc_d <= 1'b0;
    end else begin
      crs_d <= crs_s;
      rxc_d <= rxc_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= FR_IDLE;
      sfd_sh <= '0;
      cnt    <= '0;
      window <= '0;
      done   <= 1'b0;
      good   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        state <= FR_IDLE;
      end else if (car_rise) begin
        state  <= FR_HUNT;
        sfd_sh <= '0;
        cnt    <= '0;
      end else if (car_fall && state != FR_IDLE) begin
        done  <= 1'b1;
        good  <= (state == FR_BODY) && (cnt == CNT_FULL);
        state <= FR_IDLE;
      end else if (bit_stb && state != FR_IDLE) begin
        window <= {rxd_s, window[REC_BITS-1:1]};
        if (state == FR_HUNT) begin
          sfd_sh <= sfd_next;
          if (sfd_next == SFD_VAL) state <= FR_BODY;
        end else begin
          cnt <= CNT_W'(sat_inc(int'(cnt), REC_BITS));
        end
      end
    end
  end

  // R5: the status bit count never passes the record length
  a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_FULL);

  // R10: frame end is reported as a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: with processing disabled no frame end is raised
  a_r9_off_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !done);

endmodule

// File: rtl/mgmt_validate.sv
module mgmt_validate #(
  parameter int REC_BITS = 56,
  parameter int ID_W     = 6,
  parameter int PORT_W   = 4,
  parameter int MAX_PORT = 13,
  parameter int ID_LSB   = 0,
  parameter int PORT_LSB = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done,
  input  logic                good,
  input  logic [REC_BITS-1:0] window,
  input  logic [ID_W-1:0]     id0,
  input  logic [ID_W-1:0]     id1,
  input  logic                rec_ready,
  output logic                rec_valid,
  output logic [REC_BITS-1:0] rec_data,
  output logic                rec_sel,
  output logic [PORT_W-1:0]   rec_port,
  output logic                err_bus,
  output logic                err_port
);

  localparam logic [PORT_W-1:0] PORT_LIM = PORT_W'(MAX_PORT);

  logic [ID_W-1:0]   rid;
  logic [PORT_W-1:0] rport;
  logic              m0, m1, hit, port_ok, load;

  always_comb begin
    rid     = window[ID_LSB +: ID_W];
    rport   = window[PORT_LSB +: PORT_W];
    m0      = (rid == id0);
    m1      = (rid == id1);
    hit     = m0 | m1;
    port_ok = (rport <= PORT_LIM);
    load    = done & good & hit & port_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_data  <= '0;
      rec_sel   <= 1'b0;
      rec_port  <= '0;
      err_bus   <= 1'b0;
      err_port  <= 1'b0;
    end else begin
      err_bus  <= done & ~good;
      err_port <= done & good & hit & ~port_ok;
      if (rec_valid && rec_ready) rec_valid <= 1'b0;
      if (load && (!rec_valid || rec_ready)) begin
        rec_valid <= 1'b1;
        rec_data  <= window;
        rec_sel   <= ~m0;
        rec_port  <= rport;
      end
    end
  end

  // R11: a record not taken stays put
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data) &&
                                   $stable(rec_sel) && $stable(rec_port)));

  // R8: no offered record carries an out-of-range port
  a_r8_port_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_port <= PORT_LIM));

  // R6: a new record's ID equals the ID of the section it selects
  a_r6_sel_matches_id: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_valid) |-> (rec_data[ID_LSB +: ID_W] ==
                          (rec_sel ? $past(id1) : $past(id0))));

  // R10: error pulses last one cycle and never coincide
  a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (err_bus || err_port) |=> !(err_bus || err_port));

  a_r10_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_bus, err_port}));

endmodule

// File: rtl/mgmt_status_rx.sv
module mgmt_status_rx #(
  parameter int         REC_BITS = 56,
  parameter int         ID_W     = 6,
  parameter int         PORT_W   = 4,
  parameter int         MAX_PORT = 13,
  parameter int         ID_LSB   = 0,
  parameter int         PORT_LSB = 8,
  parameter int         SFD_W    = 8,
  parameter logic [7:0] SFD_VAL  = 8'hD5,
  parameter int         STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                crs_pol,
  input  logic [ID_W-1:0]     id0,
  input  logic [ID_W-1:0]     id1,
  input  logic                mrxc,
  input  logic                mrxd,
  input  logic                mcrs,
  output logic                rec_valid,
  input  logic                rec_ready,
  output logic [REC_BITS-1:0] rec_data,
  output logic                rec_sel,
  output logic [PORT_W-1:0]   rec_port,
  output logic                err_bus,
  output logic                err_port
);

  localparam int NSYNC = 3;

  logic [NSYNC-1:0]    sync_q;
  logic                done, good;
  logic [REC_BITS-1:0] window;

  mgmt_sync #(.W(NSYNC), .STAGES(STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({mcrs, mrxc, mrxd}),
    .q     (sync_q)
  );

  mgmt_shifter #(
    .REC_BITS (REC_BITS),
    .SFD_W    (SFD_W),
    .SFD_VAL  (SFD_W'(SFD_VAL))
  ) shift_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .crs_pol (crs_pol),
    .crs_s   (sync_q[2]),
    .rxc_s   (sync_q[1]),
    .rxd_s   (sync_q[0]),
    .done    (done),
    .good    (good),
    .window  (window)
  );

  mgmt_validate #(
    .REC_BITS (REC_BITS),
    .ID_W     (ID_W),
    .PORT_W   (PORT_W),
    .MAX_PORT (MAX_PORT),
    .ID_LSB   (ID_LSB),
    .PORT_LSB (PORT_LSB)
  ) val_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .good      (good),
    .window    (window),
    .id0       (id0),
    .id1       (id1),
    .rec_ready (rec_ready),
    .rec_valid (rec_valid),
    .rec_data  (rec_data),
    .rec_sel   (rec_sel),
    .rec_port  (rec_port),
    .err_bus   (err_bus),
    .err_port  (err_port)
  );

endmodule

// File: tb/mgmt_status_rx_tb.sv
module mgmt_status_rx_tb_top;

  localparam time CLK_PERIOD = 25ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        crs_pol = 1'b1;
  logic [5:0]  id0 = 6'h12;
  logic [5:0]  id1 = 6'h2B;
  logic        mrxc = 1'b0;
  logic        mrxd = 1'b0;
  logic        mcrs = 1'b0;
  logic        rec_valid;
  logic        rec_ready = 1'b1;
  logic [55:0] rec_data;
  logic        rec_sel;
  logic [3:0]  rec_port;
  logic        err_bus;
  logic        err_port;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // bench model of the held record
  bit          pv = 0;
  logic [55:0] prec = '0;
  bit          psel = 0;
  logic [3:0]  pport = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_status_rx dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .crs_pol(crs_pol), .id0(id0), .id1(id1),
    .mrxc(mrxc), .mrxd(mrxd), .mcrs(mcrs), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_data(rec_data), .rec_sel(rec_sel),
    .rec_port(rec_port), .err_bus(err_bus), .err_port(err_port)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [55:0] mk_rec(input logic [5:0] id, input logic [3:0] port,
                                         input logic [39:0] fill);
    return {fill, 4'h0, port, 2'b00, id};
  endfunction

  task automatic drive_bit(input logic b);
    mrxd = b; mrxc = 1'b0;
    @(negedge clk); @(negedge clk);
    mrxc = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic drive_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) drive_bit(v[i]);
  endtask

  // Sends one frame and checks the outcome at the due cycles.
  task automatic run_frame(input string req, input bit with_sfd, input int n_extra,
                           input logic [55:0] rec, input int nbits);
    int post;
    bit exp_eb, exp_ep, load, m0, m1;
    post   = with_sfd ? n_extra * 8 + nbits : 0;
    m0     = (rec[5:0] == id0);
    m1     = (rec[5:0] == id1);
    exp_eb = en && (!with_sfd || post < 56);
    exp_ep = en && !exp_eb && (m0 || m1) && (rec[11:8] > 4'd13);
    load   = en && !exp_eb && (m0 || m1) && (rec[11:8] <= 4'd13);
    mcrs = crs_pol;
    @(negedge clk); @(negedge clk);
    for (int p = 0; p < 7; p++) drive_byte(8'h55);
    if (with_sfd) drive_byte(8'hD5);
    for (int e = 0; e < n_extra; e++) drive_byte(8'hA3 ^ 8'(e * 37));
    for (int i = 0; i < nbits; i++) drive_bit(rec[i]);
    mcrs = ~crs_pol; mrxc = 1'b0;
    for (int k = 1; k <= 3; k++) @(negedge clk);
    check(rec_valid == pv, req, "R10 valid early", 64'(rec_valid), 64'(pv));
    check(!err_bus && !err_port, req, "R10 error early", {err_bus, err_port}, 0);
    @(negedge clk);
    if (load && (!pv || rec_ready)) begin
      pv = 1; prec = rec; psel = !m0; pport = rec[11:8];
    end
    check(rec_valid == pv, req, "valid", 64'(rec_valid), 64'(pv));
    if (pv) begin
      check(rec_data == prec, req, "R3 data", 64'(rec_data), 64'(prec));
      check(rec_sel == psel, req, "R6 sel", 64'(rec_sel), 64'(psel));
      check(rec_port == pport, req, "R8 port", 64'(rec_port), 64'(pport));
    end
    check(err_bus == exp_eb, req, "err_bus", 64'(err_bus), 64'(exp_eb));
    check(err_port == exp_ep, req, "err_port", 64'(err_port), 64'(exp_ep));
    @(negedge clk);
    if (rec_ready) pv = 0;
    check(rec_valid == pv, req, "R11 valid after", 64'(rec_valid), 64'(pv));
    check(!err_bus && !err_port, req, "R10 pulse width", {err_bus, err_port}, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(!rec_valid && !err_bus && !err_port, "R1", "outputs in reset",
          {rec_valid, err_bus, err_port}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(!rec_valid && !err_bus && !err_port, "R1", "outputs idle",
          {rec_valid, err_bus, err_port}, 0);
    en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_basic;
    run_frame("R3", 1, 0, mk_rec(6'h12, 4'd3, 40'hC3_5A_F0_19_7E), 56);
    run_frame("R6", 1, 0, mk_rec(6'h2B, 4'd0, 40'h01_23_45_67_89), 56);
  endtask

  task automatic t_priority;
    id1 = 6'h12;
    run_frame("R6", 1, 0, mk_rec(6'h12, 4'd7, 40'hFF_00_FF_00_AA), 56);
    id1 = 6'h2B;
  endtask

  task automatic t_long;
    run_frame("R3", 1, 9, mk_rec(6'h2B, 4'd11, 40'h9E_37_79_B9_7F), 56);
  endtask

  task automatic t_no_sfd;
    run_frame("R4", 0, 0, 56'h0, 56);
  endtask

  task automatic t_short;
    run_frame("R5", 1, 0, mk_rec(6'h12, 4'd2, 40'h11_22_33_44_55), 55);
    run_frame("R5", 1, 0, mk_rec(6'h12, 4'd2, 40'h11_22_33_44_55), 56);
  endtask

  task automatic t_ports;
    run_frame("R8", 1, 0, mk_rec(6'h12, 4'd13, 40'h0F_0F_0F_0F_0F), 56);
    run_frame("R8", 1, 0, mk_rec(6'h2B, 4'd14, 40'h0F_0F_0F_0F_0F), 56);
    run_frame("R8", 1, 0, mk_rec(6'h12, 4'd15, 40'h0F_0F_0F_0F_0F), 56);
  endtask

  task automatic t_nomatch;
    run_frame("R7", 1, 0, mk_rec(6'h3F, 4'd15, 40'h12_34_56_78_9A), 56);
  endtask

  task automatic t_polarity;
    en = 1'b0; crs_pol = 1'b0; mcrs = 1'b1;
    repeat (6) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    run_frame("R2", 1, 0, mk_rec(6'h2B, 4'd5, 40'hDE_AD_BE_EF_01), 56);
    en = 1'b0; crs_pol = 1'b1; mcrs = 1'b0;
    repeat (6) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    run_frame("R2", 1, 0, mk_rec(6'h12, 4'd9, 40'h55_AA_55_AA_33), 56);
  endtask

  task automatic t_disabled;
    en = 1'b0;
    run_frame("R9", 1, 0, mk_rec(6'h12, 4'd1, 40'h44_44_44_44_44), 56);
    run_frame("R9", 0, 0, 56'h0, 56);
    en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_hold;
    rec_ready = 1'b0;
    run_frame("R11", 1, 0, mk_rec(6'h12, 4'd4, 40'hAB_CD_EF_01_23), 56);
    run_frame("R11", 1, 0, mk_rec(6'h2B, 4'd6, 40'h76_54_32_10_FE), 56);
    check(rec_valid && rec_data == mk_rec(6'h12, 4'd4, 40'hAB_CD_EF_01_23), "R11",
          "first record kept", 64'(rec_data), 64'(mk_rec(6'h12, 4'd4, 40'hAB_CD_EF_01_23)));
    rec_ready = 1'b1;
    @(negedge clk);
    pv = 0;
    check(!rec_valid, "R11", "released", 64'(rec_valid), 0);
    repeat (8) @(negedge clk);
    check(!rec_valid, "R11", "second record dropped", 64'(rec_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_priority();
    t_long();
    t_no_sfd();
    t_short();
    t_ports();
    t_nomatch();
    t_polarity();
    t_disabled();
    t_hold();
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule